// File: doc/BRIEF.md
# Secondary Core Boot Release Table

This block keeps a table of start records, one for each core. Boot software on the primary core fills in a record through a byte-addressed, big-endian register port. While a core's start address has bit 0 set, that core stays parked. When a write leaves bit 0 clear, the block releases the core. It raises a one-cycle pulse on that core's release line. On shared buses it presents the start offset inside a 64 MiB window, the 64 MiB-aligned mapping base, the argument value, the window size and the encoded window size. The block overwrites the record's identity word with the core's hardware ID, so software can see that the release happened.

The table has `TABLE_RECS` records of 32 bytes each. Only indices below `NUM_CORES` are cores that exist. The request port takes one request at a time. Each accepted request gets a response on the following cycle.

A small state machine orders the work. Its states are:
- `ST_IDLE`, which accepts requests.
- `ST_EVAL`, which examines the start-address bit of the record just written.
- `ST_LAUNCH`, which drives the release pulse.

Its transitions are:
- `ST_IDLE`→`ST_EVAL` on an accepted, well-formed write to an eligible record.
- `ST_IDLE`→`ST_IDLE` on every other cycle.
- `ST_EVAL`→`ST_LAUNCH` when bit 0 is clear.
- `ST_EVAL`→`ST_IDLE` when bit 0 is set.
- `ST_LAUNCH`→`ST_IDLE` always.

Top module: `boot_release_table`

## Requirements
- R1: After reset, every record holds the following, with all other bytes zero:
  - start address = 1
  - argument (bytes 8..15, big-endian) = the record index
  - identity word (bytes 20..23) = the record index
- R2: Reads use the address split record = addr[9:5] and byte offset = addr[4:0]. They return 1, 2 or 4 bytes, big-endian from the addressed offset, right-aligned and zero-extended in `rsp_rdata_o`.
- R3: Writes of 1, 2 or 4 bytes store the low-order bytes of `req_wdata_i` big-endian, starting at the addressed offset. The size code is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes.
- R4: A request with size code 3, or with an offset that is not a multiple of its size, returns `rsp_err_o` = 1 and read data 0. Such a write changes nothing.
- R5: Writes to record 0, or to a record index of `NUM_CORES` or above, are accepted without error, change no byte and release nothing.
- R6: Every request accepted at a clock edge (`req_valid_i` high while `req_ready_o` is high) has `rsp_valid_o` high during exactly the following cycle.
- R7: After an accepted, eligible write, the block examines bit 0 of byte offset 7 (the least significant bit of the start address). If that bit is 0, `rel_pulse_o[core]` is high for exactly one cycle. This is the cycle that starts two edges after the acceptance edge. At most one pulse bit is ever high, and bit 0 never is.
- R8: With a release pulse, the outputs carry:
  - `rel_pc_o` = start & (2^26−1)
  - `rel_base_o` = start with bits 25:0 cleared
  - `rel_arg_o` = the 64-bit argument
  - `rel_map_size_o` = 2^26
  - `rel_size_code_o` = 8
- R9: All release outputs hold their values until the next release pulse.
- R10: On release, bytes 20..23 of the released record are overwritten with that core's word from `core_hwid_i`, big-endian.
- R11: Any eligible write that leaves bit 0 clear releases the core again, even if it was released before. A write that leaves bit 0 set releases nothing.
- R12: `req_ready_o` is high only in `ST_IDLE`. After an eligible write it is low for the evaluation cycle, and also for the launch cycle when a release follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = invalid |
| req_addr_i | input | ADDR_W (10) | Byte address into the table |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Response for the request accepted at the previous edge |
| rsp_err_o | output | 1 | Bad size or misaligned request |
| rsp_rdata_o | output | 32 | Read data, right-aligned |
| core_hwid_i | input | NUM_CORES*32 | Hardware ID of each core, core i at bits [32i+31:32i] |
| rel_pulse_o | output | NUM_CORES | One-cycle release strobe per core |
| rel_pc_o | output | 64 | Start offset within the mapping window |
| rel_arg_o | output | 64 | Argument value for the released core |
| rel_base_o | output | 64 | Window-aligned mapping base |
| rel_map_size_o | output | 64 | Mapping window size in bytes |
| rel_size_code_o | output | 4 | Encoded window size |

## Verification
Each result has a fixed cycle:
- A read's data and error flag, and a write's response, are due in the cycle after the acceptance edge.
- Bytes written are visible to the next accepted read.
- A release pulse and its parameters are due one cycle later still, in the launch cycle.
- The rewritten identity word can be read back from the first request accepted after that.

Every transfer task drives inputs on the falling edge and samples the response at the falling edge that follows acceptance. It then samples the release outputs at the next falling edge. This way, each check lands in the one cycle where the requirement says the value is present, and the bench also confirms that no pulse appears early.

// File: rtl/brt_pkg.sv
package brt_pkg;

    localparam int unsigned REC_BYTES = 32;
    localparam int unsigned OFF_W     = 5;

    // byte offsets whose positions the release logic depends on
    localparam int unsigned OFF_START = 0;
    localparam int unsigned OFF_ARG   = 8;
    localparam int unsigned OFF_HWID  = 20;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVAL   = 2'd1,
        ST_LAUNCH = 2'd2
    } brt_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } brt_size_e;

    function automatic int unsigned size_bytes(logic [1:0] sz);
        unique case (sz)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            SZ_WORD: return 4;
            default: return 0;
        endcase
    endfunction

    // byte k (0 = most significant of the transfer) of a right-aligned value
    function automatic logic [7:0] be_byte(logic [31:0] d, int unsigned nb, int unsigned k);
        logic [31:0] s;
        s = d >> (8 * (nb - 1 - k));
        return s[7:0];
    endfunction

    // trailing zeros of (size >> 10), halved
    function automatic logic [3:0] map_code(int unsigned shift);
        int unsigned c;
        c = (shift - 10) >> 1;
        return c[3:0];
    endfunction

endpackage

// File: rtl/brt_decode.sv
module brt_decode
    import brt_pkg::*;
#(
    parameter int unsigned TABLE_RECS = 32,
    parameter int unsigned NUM_CORES  = 8,
    localparam int unsigned IDX_W     = $clog2(TABLE_RECS),
    localparam int unsigned ADDR_W    = IDX_W + OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [IDX_W-1:0]  rec_idx,
    output logic [OFF_W-1:0]  byte_off,
    output logic              bad,
    output logic              eligible
);

    logic misaligned;

    assign rec_idx  = addr[ADDR_W-1:OFF_W];
    assign byte_off = addr[OFF_W-1:0];

    always_comb begin
        misaligned = 1'b0;
        unique case (size)
            SZ_HALF: misaligned = byte_off[0];
            SZ_WORD: misaligned = |byte_off[1:0];
            default: misaligned = 1'b0;
        endcase
    end

    assign bad      = (size == SZ_BAD) || misaligned;
    assign eligible = (rec_idx != '0) && (32'(rec_idx) < NUM_CORES);

endmodule

// File: rtl/brt_regfile.sv
module brt_regfile
    import brt_pkg::*;
#(
    parameter int unsigned TABLE_RECS = 32,
    localparam int unsigned IDX_W     = $clog2(TABLE_RECS)
) (
    input  logic             clk,
    input  logic             rst_n,
    // software write port
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [1:0]       wr_size,
    input  logic [31:0]      wr_data,
    // identity rewrite port
    input  logic             id_en,
    input  logic [IDX_W-1:0] id_idx,
    input  logic [31:0]      id_val,
    // software read port
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [OFF_W-1:0] rd_off,
    input  logic [1:0]       rd_size,
    output logic [31:0]      rd_data,
    // release view of one record
    input  logic [IDX_W-1:0] sel_idx,
    output logic [63:0]      sel_start,
    output logic [63:0]      sel_arg
);

    logic [7:0] mem [TABLE_RECS][REC_BYTES];

    function automatic logic [7:0] init_byte(int unsigned r, int unsigned b);
        logic [31:0] rv;
        rv = r;
        if (b == OFF_START + 7) return 8'h01;
        if (b == OFF_ARG + 7)   return rv[7:0];
        if (b == OFF_ARG + 6)   return rv[15:8];
        if (b == OFF_HWID + 3)  return rv[7:0];
        if (b == OFF_HWID + 2)  return rv[15:8];
        return 8'h00;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < int'(TABLE_RECS); r++) begin
                for (int b = 0; b < int'(REC_BYTES); b++) begin
                    mem[r][b] <= init_byte(r, b);
                end
            end
        end else begin
            if (wr_en) begin
                for (int k = 0; k < 4; k++) begin
                    if (k < int'(size_bytes(wr_size))) begin
                        mem[wr_idx][wr_off + OFF_W'(k)] <=
                            be_byte(wr_data, size_bytes(wr_size), k);
                    end
                end
            end
            if (id_en) begin
                for (int k = 0; k < 4; k++) begin
                    mem[id_idx][OFF_W'(OFF_HWID + k)] <= be_byte(id_val, 4, k);
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < int'(size_bytes(rd_size))) begin
                rd_data = {rd_data[23:0], mem[rd_idx][rd_off + OFF_W'(k)]};
            end
        end
    end

    always_comb begin
        sel_start = '0;
        sel_arg   = '0;
        for (int k = 0; k < 8; k++) begin
            sel_start = {sel_start[55:0], mem[sel_idx][OFF_START + k]};
            sel_arg   = {sel_arg[55:0],   mem[sel_idx][OFF_ARG + k]};
        end
    end

endmodule

// File: rtl/brt_launch.sv
module brt_launch
    import brt_pkg::*;
#(
    parameter int unsigned MAP_SHIFT = 26
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        capture,
    input  logic [63:0] start,
    input  logic [63:0] arg,
    output logic [63:0] pc,
    output logic [63:0] base,
    output logic [63:0] arg_q,
    output logic [63:0] map_size,
    output logic [3:0]  size_code
);

    localparam logic [63:0] WIN_MASK = (64'd1 << MAP_SHIFT) - 64'd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc    <= '0;
            base  <= '0;
            arg_q <= '0;
        end else if (capture) begin
            pc    <= start & WIN_MASK;
            base  <= start & ~WIN_MASK;
            arg_q <= arg;
        end
    end

    assign map_size  = 64'd1 << MAP_SHIFT;
    assign size_code = map_code(MAP_SHIFT);

endmodule

// File: rtl/boot_release_table.sv
module boot_release_table
    import brt_pkg::*;
#(
    parameter int unsigned TABLE_RECS = 32,
    parameter int unsigned NUM_CORES  = 8,
    parameter int unsigned MAP_SHIFT  = 26,
    localparam int unsigned IDX_W     = $clog2(TABLE_RECS),
    localparam int unsigned ADDR_W    = IDX_W + OFF_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid_i,
    output logic                   req_ready_o,
    input  logic                   req_write_i,
    input  logic [1:0]             req_size_i,
    input  logic [ADDR_W-1:0]      req_addr_i,
    input  logic [31:0]            req_wdata_i,
    output logic                   rsp_valid_o,
    output logic                   rsp_err_o,
    output logic [31:0]            rsp_rdata_o,
    input  logic [NUM_CORES*32-1:0] core_hwid_i,
    output logic [NUM_CORES-1:0]   rel_pulse_o,
    output logic [63:0]            rel_pc_o,
    output logic [63:0]            rel_arg_o,
    output logic [63:0]            rel_base_o,
    output logic [63:0]            rel_map_size_o,
    output logic [3:0]             rel_size_code_o
);

    brt_state_e       state_q, state_d;
    logic [IDX_W-1:0] cur_idx_q;

    logic [IDX_W-1:0] dec_idx;
    logic [OFF_W-1:0] dec_off;
    logic             dec_bad;
    logic             dec_elig;

    logic             accept;
    logic             do_write;
    logic             do_release;
    logic [31:0]      rd_word;
    logic [63:0]      sel_start;
    logic [63:0]      sel_arg;
    logic [31:0]      hwid_sel;

    brt_decode #(
        .TABLE_RECS (TABLE_RECS),
        .NUM_CORES  (NUM_CORES)
    ) u_decode (
        .addr     (req_addr_i),
        .size     (req_size_i),
        .rec_idx  (dec_idx),
        .byte_off (dec_off),
        .bad      (dec_bad),
        .eligible (dec_elig)
    );

    assign accept     = req_valid_i && (state_q == ST_IDLE);
    assign do_write   = accept && req_write_i && !dec_bad && dec_elig;
    assign do_release = (state_q == ST_EVAL) && !sel_start[0];

    always_comb begin
        hwid_sel = '0;
        for (int i = 0; i < int'(NUM_CORES); i++) begin
            if (32'(cur_idx_q) == i) hwid_sel = core_hwid_i[i*32 +: 32];
        end
    end

    brt_regfile #(
        .TABLE_RECS (TABLE_RECS)
    ) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (do_write),
        .wr_idx    (dec_idx),
        .wr_off    (dec_off),
        .wr_size   (req_size_i),
        .wr_data   (req_wdata_i),
        .id_en     (do_release),
        .id_idx    (cur_idx_q),
        .id_val    (hwid_sel),
        .rd_idx    (dec_idx),
        .rd_off    (dec_off),
        .rd_size   (req_size_i),
        .rd_data   (rd_word),
        .sel_idx   (cur_idx_q),
        .sel_start (sel_start),
        .sel_arg   (sel_arg)
    );

    brt_launch #(
        .MAP_SHIFT (MAP_SHIFT)
    ) u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (do_release),
        .start     (sel_start),
        .arg       (sel_arg),
        .pc        (rel_pc_o),
        .base      (rel_base_o),
        .arg_q     (rel_arg_o),
        .map_size  (rel_map_size_o),
        .size_code (rel_size_code_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (do_write) state_d = ST_EVAL;
            ST_EVAL:   state_d = do_release ? ST_LAUNCH : ST_IDLE;
            ST_LAUNCH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (do_write) cur_idx_q <= dec_idx;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_err_o   <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_valid_o <= accept;
            rsp_err_o   <= accept && dec_bad;
            rsp_rdata_o <= (accept && !req_write_i && !dec_bad) ? rd_word : '0;
        end
    end

    assign req_ready_o = (state_q == ST_IDLE);

    always_comb begin
        rel_pulse_o = '0;
        if (state_q == ST_LAUNCH) begin
            for (int i = 1; i < int'(NUM_CORES); i++) begin
                if (32'(cur_idx_q) == i) rel_pulse_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
    parameter int unsigned NUM_CORES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid_i,
    input logic                 req_ready_o,
    input logic                 rsp_valid_o,
    input logic                 rsp_err_o,
    input logic [NUM_CORES-1:0] rel_pulse_o,
    input logic [63:0]          rel_pc_o,
    input logic [63:0]          rel_arg_o,
    input logic [63:0]          rel_base_o
);

    // R7
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rel_pulse_o));

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel_pulse_o) |=> (rel_pulse_o == '0));

    // R5
    primary_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_pulse_o[0]);

    // R9
    hold_params_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|rel_pulse_o) |-> ($stable(rel_pc_o) && $stable(rel_arg_o) && $stable(rel_base_o)));

    // R6
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid_i && req_ready_o));

    // R6
    rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> rsp_valid_o);

    // R4
    err_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_o |-> rsp_valid_o);

    // R12
    busy_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel_pulse_o) |-> (!req_ready_o && $past(!req_ready_o)));

endmodule

bind boot_release_table brt_checker #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .rel_pulse_o (rel_pulse_o),
    .rel_pc_o    (rel_pc_o),
    .rel_arg_o   (rel_arg_o),
    .rel_base_o  (rel_base_o)
);

// File: tb/tb_boot_release_table.sv
module tb_boot_release_table;

    localparam int NC = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [1:0]        req_size = 2'd0;
    logic [9:0]        req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_err;
    logic [31:0]       rsp_rdata;
    logic [NC*32-1:0]  hwid;
    logic [NC-1:0]     rel_pulse;
    logic [63:0]       rel_pc, rel_arg, rel_base, rel_msize;
    logic [3:0]        rel_code;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    // sampled results of the last transfer
    logic        s_rv, s_err, s_rdy;
    logic [31:0] s_rd;
    logic [NC-1:0] s_p0, s_p1;
    logic [63:0] s_pc, s_arg, s_base, s_msize;
    logic [3:0]  s_code;

    always #2 clk = ~clk;

    for (genvar g = 0; g < NC; g++) begin : g_id
        assign hwid[g*32 +: 32] = 32'hC0DE_0000 + 32'(g);
    end

    boot_release_table #(.TABLE_RECS(32), .NUM_CORES(NC), .MAP_SHIFT(26)) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid_i     (req_valid),
        .req_ready_o     (req_ready),
        .req_write_i     (req_write),
        .req_size_i      (req_size),
        .req_addr_i      (req_addr),
        .req_wdata_i     (req_wdata),
        .rsp_valid_o     (rsp_valid),
        .rsp_err_o       (rsp_err),
        .rsp_rdata_o     (rsp_rdata),
        .core_hwid_i     (hwid),
        .rel_pulse_o     (rel_pulse),
        .rel_pc_o        (rel_pc),
        .rel_arg_o       (rel_arg),
        .rel_base_o      (rel_base),
        .rel_map_size_o  (rel_msize),
        .rel_size_code_o (rel_code)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [1:0] sz, input logic [4:0] rec,
                        input logic [4:0] off, input logic [31:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_size = sz;
        req_addr  = {rec, off}; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        s_rv = rsp_valid; s_err = rsp_err; s_rd = rsp_rdata;
        s_p0 = rel_pulse; s_rdy = req_ready;
        @(negedge clk);
        s_p1 = rel_pulse; s_pc = rel_pc; s_arg = rel_arg; s_base = rel_base;
        s_msize = rel_msize; s_code = rel_code;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] sz, input logic [4:0] rec,
                          input logic [4:0] off, input logic [31:0] exp);
        xfer(1'b0, sz, rec, off, 32'h0);
        chk({tag, " rsp_valid"}, 64'(s_rv), 64'd1);
        chk({tag, " rdata"}, 64'(s_rd), 64'(exp));
    endtask

    task automatic t_reset;
        chk("R1 ready after reset", 64'(req_ready), 64'd1);
        chk("R7 no pulse after reset", 64'(rel_pulse), 64'd0);
        rd_chk("R1 start hi", 2'd2, 5'd3, 5'd0, 32'h0);
        rd_chk("R1 start lo", 2'd2, 5'd3, 5'd4, 32'h1);
        rd_chk("R1 arg hi", 2'd2, 5'd3, 5'd8, 32'h0);
        rd_chk("R1 arg lo", 2'd2, 5'd3, 5'd12, 32'h3);
        rd_chk("R1 id", 2'd2, 5'd20, 5'd20, 32'd20);
        rd_chk("R1 reserved", 2'd2, 5'd3, 5'd28, 32'h0);
        chk("R6 read err", 64'(s_err), 64'd0);
    endtask

    task automatic t_endian;
        xfer(1'b1, 2'd2, 5'd5, 5'd8, 32'hA1B2_C3D4);
        chk("R11 arg write no release", 64'(s_p1), 64'd0);
        chk("R12 ready low in eval", 64'(s_rdy), 64'd0);
        rd_chk("R2 byte read", 2'd0, 5'd5, 5'd9, 32'hB2);
        rd_chk("R2 half read", 2'd1, 5'd5, 5'd10, 32'hC3D4);
        xfer(1'b1, 2'd0, 5'd5, 5'd11, 32'h0000_005E);
        rd_chk("R3 byte write", 2'd2, 5'd5, 5'd8, 32'hA1B2_C35E);
        xfer(1'b1, 2'd1, 5'd5, 5'd16, 32'h0000_1234);
        rd_chk("R3 half write", 2'd2, 5'd5, 5'd16, 32'h1234_0000);
    endtask

    task automatic t_errors;
        xfer(1'b0, 2'd3, 5'd5, 5'd8, 32'h0);
        chk("R4 bad size err", 64'(s_err), 64'd1);
        chk("R4 bad size data", 64'(s_rd), 64'd0);
        xfer(1'b0, 2'd2, 5'd5, 5'd10, 32'h0);
        chk("R4 misaligned read err", 64'(s_err), 64'd1);
        xfer(1'b1, 2'd1, 5'd5, 5'd13, 32'h0000_FFFF);
        chk("R4 misaligned write err", 64'(s_err), 64'd1);
        rd_chk("R4 write ignored", 2'd2, 5'd5, 5'd12, 32'h5);
        xfer(1'b1, 2'd3, 5'd6, 5'd4, 32'h0);
        chk("R4 bad size write no release", 64'(s_p1), 64'd0);
        rd_chk("R4 bad size write ignored", 2'd2, 5'd6, 5'd4, 32'h1);
    endtask

    task automatic t_ignored;
        xfer(1'b1, 2'd2, 5'd0, 5'd4, 32'h0);
        chk("R5 rec0 no err", 64'(s_err), 64'd0);
        chk("R5 rec0 no pulse", 64'(s_p1), 64'd0);
        chk("R5 rec0 ready", 64'(s_rdy), 64'd1);
        rd_chk("R5 rec0 unchanged", 2'd2, 5'd0, 5'd4, 32'h1);
        xfer(1'b1, 2'd2, 5'(NC), 5'd4, 32'h0);
        chk("R5 absent no pulse", 64'(s_p1), 64'd0);
        rd_chk("R5 absent unchanged", 2'd2, 5'(NC), 5'd4, 32'h1);
    endtask

    task automatic t_release;
        xfer(1'b1, 2'd2, 5'd2, 5'd0, 32'h0000_0001);
        chk("R11 hi write held", 64'(s_p1), 64'd0);
        xfer(1'b1, 2'd2, 5'd2, 5'd8, 32'hDEAD_BEEF);
        xfer(1'b1, 2'd2, 5'd2, 5'd12, 32'h0000_0042);
        xfer(1'b1, 2'd2, 5'd2, 5'd4, 32'h0A12_3454);
        chk("R7 no early pulse", 64'(s_p0), 64'd0);
        chk("R7 pulse core2", 64'(s_p1), 64'(8'b0000_0100));
        chk("R8 pc", s_pc, 64'h0000_0000_0212_3454);
        chk("R8 base", s_base, 64'h0000_0001_0800_0000);
        chk("R8 arg", s_arg, 64'hDEAD_BEEF_0000_0042);
        chk("R8 map size", s_msize, 64'h0000_0000_0400_0000);
        chk("R8 size code", 64'(s_code), 64'd8);
        chk("R12 ready low at launch", 64'(req_ready), 64'd0);
        rd_chk("R10 id rewritten", 2'd2, 5'd2, 5'd20, 32'hC0DE_0002);
        rd_chk("R10 start kept", 2'd2, 5'd2, 5'd4, 32'h0A12_3454);
    endtask

    task automatic t_hold;
        xfer(1'b1, 2'd2, 5'd6, 5'd8, 32'h1111_2222);
        rd_chk("R9 read", 2'd2, 5'd6, 5'd8, 32'h1111_2222);
        chk("R9 pc held", rel_pc, 64'h0000_0000_0212_3454);
        chk("R9 arg held", rel_arg, 64'hDEAD_BEEF_0000_0042);
        chk("R9 base held", rel_base, 64'h0000_0001_0800_0000);
    endtask

    task automatic t_rerelease;
        xfer(1'b1, 2'd0, 5'd2, 5'd15, 32'h0000_0099);
        chk("R11 re-release core2", 64'(s_p1), 64'(8'b0000_0100));
        chk("R11 new arg", s_arg, 64'hDEAD_BEEF_0000_0099);
        xfer(1'b1, 2'd0, 5'd3, 5'd7, 32'h0000_0000);
        chk("R11 byte release core3", 64'(s_p1), 64'(8'b0000_1000));
        chk("R8 zero pc", s_pc, 64'h0);
        chk("R8 reset arg", s_arg, 64'h3);
        xfer(1'b1, 2'd0, 5'd3, 5'd7, 32'h0000_0001);
        chk("R11 set bit no release", 64'(s_p1), 64'd0);
        xfer(1'b1, 2'd1, 5'd4, 5'd6, 32'h0000_1000);
        chk("R7 half release core4", 64'(s_p1), 64'(8'b0001_0000));
        chk("R8 half pc", s_pc, 64'h1000);
        chk("R8 half base", s_base, 64'h0);
        rd_chk("R10 id core4", 2'd2, 5'd4, 5'd20, 32'hC0DE_0004);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<50000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_endian();
        t_errors();
        t_ignored();
        t_release();
        t_hold();
        t_rerelease();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule